// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side sequencer for a 12-bit successive-approximation converter that talks over three wires: an active-low chip select, a serial clock and a single data line coming back from the converter. A start request lowers chip select, which starts a conversion inside the converter. The controller then leaves the serial clock idle until the converter raises its data line to report that the conversion has finished. It then clocks the result out, most significant bit first, raises chip select and presents the 12-bit word on a parallel output together with a one-cycle valid strobe.

Two read framings are selectable per transaction. The short framing issues thirteen clock pulses: one framing pulse followed by twelve data pulses. The byte framing issues sixteen pulses, as a host that can only move whole bytes would, and drops the framing bit and the three trailing zeros. The serial clock idles low and the controller samples data at the end of each high phase, which matches clock polarity 0, phase 0. The half period of the serial clock is a programmable count of system clocks, so the clock can be kept under the converter's limit. A programmable timeout ends a conversion that never reports completion.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy, valid and error are low. The result output is zero.
- R2: A start request seen while idle drives chip select low and busy high on the next clock edge. Busy stays high until the transaction ends.
- R3: No serial clock pulse is issued before the converter drives the data line high to report end of conversion. The data line passes through a two-stage synchronizer before every test and every capture.
- R4: With byte_mode_i low, exactly 13 pulses are issued. The level sampled at the end of pulse 1 is discarded, and the levels sampled at pulses 2 to 13 become result bits 11 down to 0.
- R5: With byte_mode_i high, exactly 16 pulses are issued. Pulses 2 to 13 give bits 11 to 0, and the levels sampled at pulses 14 to 16 are discarded.
- R6: Each high phase and each low phase between pulses lasts div_i system clocks. Values below 2 act as 2. The serial clock stays low whenever chip select is high.
- R7: If end of conversion is not seen within tmo_i system clocks of the start, err_o pulses high for one cycle. Chip select returns high at the same time, no serial pulse is issued, and valid does not pulse.
- R8: A start request while busy is ignored. Chip select does not fall again and the transaction in progress finishes unchanged.
- R9: result_o changes only in the cycle where valid_o is high. valid_o is high for exactly one cycle, and it rises one cycle after chip select has returned high.
- R10: A high level on the data line that is left over from before the start, while chip select was high, is not taken as end of conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion and readout |
| byte_mode_i | input | 1 | 0: 13-pulse read, 1: 16-pulse two-byte read; sampled at start |
| div_i | input | DIV_W | Serial clock half period in system clocks; sampled at start |
| tmo_i | input | TMO_W | End-of-conversion timeout in system clocks |
| sdo_i | input | 1 | Serial data from the converter (asynchronous) |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | DATA_W | Last converted word |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| err_o | output | 1 | One-cycle strobe on conversion timeout |

## Verification
The bound checker tests several properties on every cycle. The serial clock stays quiet while chip select is high. Valid and error are single-cycle pulses that occur with chip select high. The result only moves together with valid. Chip select only falls after an accepted start. The checker also counts pulses per transaction and compares the count with the mode latched at start. Some behaviour only the bench scenarios can show. These are the bit order and the discarding of the framing and trailing bits against a converter model, the exact half-period length, and the timeout path with a silent converter. They also include rejecting start requests issued mid-transaction, and ignoring a stale high data level left over from before chip select fell.

// File: rtl/adc_rd_pkg.sv
// Package: shared types for the serial ADC readout controller.
// Holds the sequencer state encoding used by the top module.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // chip select high, waiting for start
        ST_CONV  = 3'd1,   // chip select low, waiting for end of conversion
        ST_SHIFT = 3'd2,   // issuing serial clock pulses
        ST_TAIL  = 3'd3,   // final low half period before raising chip select
        ST_DONE  = 3'd4    // chip select high, publishing the result
    } rd_state_t;

endpackage

// File: rtl/adc_rd_sync.sv
// Module: adc_rd_sync
// Multi-stage synchronizer for the asynchronous converter data line.
// Assumes STAGES >= 2. Output lags input by STAGES clock edges.
module adc_rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_rd_tick.sv
// Module: adc_rd_tick
// Half-period timer for the serial clock. While enabled it asserts tick_o
// once every div_i cycles; while disabled it holds its count at zero.
// Assumes div_i >= 1 (the top module clamps it to at least 2).
module adc_rd_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q >= (div_i - DIV_W'(1)));
    assign tick_o = en_i && wrap;

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en_i)  cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/adc_rd_shreg.sv
// Module: adc_rd_shreg
// Left-shifting capture register; new bits enter at the LSB so the
// first captured bit ends up as the MSB. clr_i has priority over shift_i.
module adc_rd_shreg #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] q_o
);

    // Clear at transaction start, shift on each accepted data sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= '0;
        else if (clr_i)   q_o <= '0;
        else if (shift_i) q_o <= {q_o[WIDTH-2:0], bit_i};
    end

endmodule

// File: rtl/adc_rd_ctrl.sv
// Module: adc_rd_ctrl
// Host-side sequencer for a three-wire serial ADC. It lowers chip select
// to start a conversion, waits for the data line to go high (end of
// conversion) and then issues 13 or 16 serial clock pulses. It samples data
// at the end of each high phase, raises chip select and publishes the word
// with a one-cycle valid strobe.
// Assumes: sdo_i is asynchronous; the converter updates data after each
// falling clock edge; mode and divider inputs are sampled at start.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int unsigned MIN_PULSES  = DATA_W + 1;
    localparam int unsigned BYTE_PULSES = ((DATA_W + 1 + 7) / 8) * 8;
    localparam int unsigned CNT_W       = $clog2(BYTE_PULSES + 1);

    rd_state_t         state_q;
    logic [CNT_W-1:0]  pcnt_q;
    logic [TMO_W-1:0]  wait_q;
    logic [DIV_W-1:0]  div_q;
    logic              mode_q;
    logic              sdo_s;
    logic              tick;
    logic              tick_en;
    logic              accept;
    logic              capture;
    logic [CNT_W-1:0]  last_pulse;
    logic [DATA_W-1:0] shreg_q;

    // Data line synchronizer ahead of end-of-conversion test and capture.
    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sdo_i),
        .q_o   (sdo_s)
    );

    // Half-period timer, running only while clocking.
    assign tick_en = (state_q == ST_SHIFT) || (state_q == ST_TAIL);

    adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .div_i  (div_q),
        .tick_o (tick)
    );

    // Capture only on falling ticks of pulses 2..DATA_W+1.
    assign accept     = (state_q == ST_IDLE) && start_i;
    assign last_pulse = mode_q ? CNT_W'(BYTE_PULSES - 1) : CNT_W'(MIN_PULSES - 1);
    assign capture    = (state_q == ST_SHIFT) && tick && sclk_o
                        && (pcnt_q >= CNT_W'(1)) && (pcnt_q <= CNT_W'(DATA_W));

    adc_rd_shreg #(.WIDTH(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .shift_i (capture),
        .bit_i   (sdo_s),
        .q_o     (shreg_q)
    );

    assign busy_o = (state_q != ST_IDLE);

    // Transaction sequencer: chip select, serial clock, result and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cs_n_o   <= 1'b1;
            sclk_o   <= 1'b0;
            pcnt_q   <= '0;
            wait_q   <= '0;
            div_q    <= DIV_W'(2);
            mode_q   <= 1'b0;
            result_o <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_CONV;
                        cs_n_o  <= 1'b0;
                        wait_q  <= '0;
                        mode_q  <= byte_mode_i;
                        div_q   <= (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
                    end
                end
                ST_CONV: begin
                    if ((wait_q >= TMO_W'(SYNC_STAGES)) && sdo_s) begin
                        state_q <= ST_SHIFT;
                        pcnt_q  <= '0;
                    end else if (wait_q >= tmo_i) begin
                        state_q <= ST_IDLE;
                        cs_n_o  <= 1'b1;
                        err_o   <= 1'b1;
                    end else begin
                        wait_q <= wait_q + TMO_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            pcnt_q <= pcnt_q + CNT_W'(1);
                            if (pcnt_q == last_pulse) state_q <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_n_o  <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    result_o <= shreg_q;
                    valid_o  <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    cs_n_o  <= 1'b1;
                    sclk_o  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
// Module: adc_rd_ctrl_chk
// Cycle-level protocol checker for adc_rd_ctrl, attached by bind.
// Tracks serial clock rising edges per transaction and the mode latched at
// an accepted start, then checks pulse counts and strobe timing.
module adc_rd_ctrl_chk #(
    parameter int unsigned DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              byte_mode_i,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              busy_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              err_o
);

    localparam int unsigned MIN_PULSES  = DATA_W + 1;
    localparam int unsigned BYTE_PULSES = ((DATA_W + 1 + 7) / 8) * 8;

    logic       sclk_prev;
    logic       mode_lat;
    logic [7:0] rise_cnt;

    // Count serial clock rises since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            mode_lat  <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (!busy_o && start_i) begin
                mode_lat <= byte_mode_i;
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_prev) begin
                rise_cnt <= rise_cnt + 8'd1;
            end
        end
    end

    // R6: serial clock only moves while chip select is low.
    a_r6_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> (!cs_n_o && !$past(cs_n_o)));

    // R6: serial clock low whenever chip select is high.
    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R4 / R5: completed read issued the pulse count of the latched mode.
    a_r4_r5_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n_o) && !err_o) |->
        (rise_cnt == (mode_lat ? 8'(BYTE_PULSES) : 8'(MIN_PULSES))));

    // R7: a timeout leaves chip select high and issues no pulse.
    a_r7_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cs_n_o && rise_cnt == 8'd0 && !valid_o));

    // R7: error is a single-cycle strobe.
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R8: chip select only falls after a start accepted while idle.
    a_r8_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!busy_o && start_i));

    // R9: valid is one cycle wide.
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: valid follows chip select having already returned high.
    a_r9_valid_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && $past(cs_n_o)));

    // R9: result only changes alongside valid.
    a_r9_result_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_mode_i (byte_mode_i),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .result_o    (result_o),
    .valid_o     (valid_o),
    .err_o       (err_o)
);

// File: tb/adc_rd_ctrl_test.sv
// Bench: directed scenarios for adc_rd_ctrl against a behavioural converter.
// The converter model drives the data line low at chip select fall, high at
// end of conversion, and presents D11..D0 after falling clock edges 1..12.
`timescale 1ns/1ps
module adc_rd_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_mode_i = 1'b0;
    logic [7:0]  div_i = 8'd3;
    logic [15:0] tmo_i = 16'd1000;
    logic        sdo_i = 1'b1;
    logic        cs_n_o, sclk_o, busy_o, valid_o, err_o;
    logic [11:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Converter model state and monitor counters.
    logic [11:0] m_data = '0;
    int  m_conv = 20;
    bit  m_never = 0;
    bit  m_eoc = 0;
    int  m_cnt = 0;
    int  m_falls = 0;
    bit  prev_cs = 1'b1;
    bit  prev_sclk = 1'b0;
    int  rises = 0, early = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    int  cs_falls = 0, valids = 0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_mode_i(byte_mode_i),
        .div_i(div_i), .tmo_i(tmo_i), .sdo_i(sdo_i), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o),
        .valid_o(valid_o), .err_o(err_o)
    );

    // Converter model and edge monitor, acting between clock edges.
    always @(negedge clk) begin
        if (cs_n_o) begin
            sdo_i   <= 1'b1;
            m_eoc   = 0;
            m_falls = 0;
        end else if (prev_cs) begin
            sdo_i    <= 1'b0;
            m_cnt    = m_conv;
            m_eoc    = 0;
            rises    = 0;
            early    = 0;
            cs_falls = cs_falls + 1;
        end else if (!m_eoc) begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else if (!m_never) begin
                sdo_i <= 1'b1;
                m_eoc = 1;
            end
        end else if (prev_sclk && !sclk_o) begin
            m_falls = m_falls + 1;
            sdo_i <= (m_falls <= 12) ? m_data[12 - m_falls] : 1'b0;
        end
        if (!cs_n_o && sclk_o && !prev_sclk) begin
            rises   = rises + 1;
            if (!m_eoc) early = early + 1;
            last_lo = lo_run;
            lo_run  = 0;
        end
        if (sclk_o) hi_run = hi_run + 1;
        else if (prev_sclk) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
        if (!sclk_o && !cs_n_o && m_eoc) lo_run = lo_run + 1;
        if (valid_o) valids = valids + 1;
        prev_cs   = cs_n_o;
        prev_sclk = sclk_o;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Full read: start, wait for valid, check word, pulses, timing.
    task automatic run_read(input bit mode, input int div, input logic [11:0] data,
                            input int conv, input bit poke_start);
        int v0, f0, n;
        @(negedge clk);
        m_data = data; m_conv = conv; m_never = 0;
        byte_mode_i = mode; div_i = 8'(div); tmo_i = 16'd1000;
        v0 = valids; f0 = cs_falls;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 cs low after start", int'(cs_n_o), 0);
        chk("R2 busy after start", int'(busy_o), 1);
        n = 0;
        while (!valid_o && n < 20000) begin
            if (poke_start) start_i = (n % 7 == 3);
            @(negedge clk);
            n = n + 1;
        end
        start_i = 1'b0;
        chk("R9 valid with cs high", int'(cs_n_o), 1);
        chk(mode ? "R5 byte result" : "R4 short result", int'(result_o), int'(data));
        chk(mode ? "R5 sixteen pulses" : "R4 thirteen pulses", rises, mode ? 16 : 13);
        chk("R3 R10 no pulse before end of conversion", early, 0);
        chk("R6 high phase length", last_hi, div < 2 ? 2 : div);
        chk("R6 low phase length", last_lo, div < 2 ? 2 : div);
        @(negedge clk);
        chk("R9 valid one cycle", int'(valid_o), 0);
        chk("R9 one valid per read", valids - v0, 1);
        chk("R2 busy cleared", int'(busy_o), 0);
        if (poke_start) chk("R8 single chip select fall", cs_falls - f0, 1);
    endtask

    task automatic t_reset();
        chk("R1 cs high", int'(cs_n_o), 1);
        chk("R1 sclk low", int'(sclk_o), 0);
        chk("R1 busy low", int'(busy_o), 0);
        chk("R1 valid low", int'(valid_o), 0);
        chk("R1 err low", int'(err_o), 0);
        chk("R1 result zero", int'(result_o), 0);
    endtask

    task automatic t_timeout();
        int n;
        logic [11:0] keep;
        keep = result_o;
        @(negedge clk);
        m_never = 1; tmo_i = 16'd40; byte_mode_i = 1'b0; div_i = 8'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!err_o && n < 2000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk("R7 err raised", int'(err_o), 1);
        chk("R7 cs high on err", int'(cs_n_o), 1);
        chk("R7 no pulses", rises, 0);
        chk("R7 timeout window", (n >= 38 && n <= 44) ? 1 : 0, 1);
        @(negedge clk);
        chk("R7 err one cycle", int'(err_o), 0);
        chk("R7 idle after err", int'(busy_o), 0);
        chk("R9 result kept after timeout", int'(result_o), int'(keep));
        m_never = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_read(1'b0, 3, 12'hA5C, 20, 1'b0);
        run_read(1'b0, 2, 12'hFFF, 12, 1'b0);
        run_read(1'b0, 5, 12'h801, 30, 1'b0);
        run_read(1'b0, 1, 12'h000, 8, 1'b0);
        run_read(1'b1, 4, 12'h3C9, 25, 1'b0);
        run_read(1'b1, 2, 12'h001, 15, 1'b0);
        t_timeout();
        run_read(1'b0, 3, 12'h6B2, 40, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule